// File: doc/BRIEF.md
# Cell Phase Measurement and Delay Selector

The block measures how far an incoming cell-start marker lags the system reference cell marker and turns that lag into a control word for a binary-weighted delay line. The whole-bit part of the lag comes from a counter that starts when the cell marker is seen, advances once per bit clock, and is frozen at the first following reference marker. The sub-bit part comes from four phase-tap samples of the cell marker. The taps sit one quarter bit apart and are sampled together by a bit-aligned strobe. The samples are supplied as inputs and decoded as a thermometer code. No clock faster than the bit clock is needed.

The result is an 11-bit word with the default parameters. Nine coarse bits select stages weighted 256 down to 1 bit. Two fine bits select a half-bit stage and a quarter-bit stage. The word's value is therefore the total inserted delay in quarter bits. A one-cycle valid strobe marks every new word. An error flag marks words whose fine samples were not a legal thermometer pattern.

Top module: `cell_skew_gauge`

## Requirements
- R1: A cell marker sampled high at bit-clock edge t0 arms the measurement. If a reference marker is then sampled high at edge t0+k (k >= 1), the coarse field holds k.
- R2: The word is updated only at the edge that samples the first reference marker after an armed cell marker. ctrl_valid is high for exactly the one cycle after that edge, and ctrl_word holds its value at all other times.
- R3: The coarse count saturates at 2^CNT_W-1 (511). A lag of 511 bits or more yields a coarse field of 511.
- R4: fine_taps is captured at the same edge as the cell marker. Bit 0 is the earliest tap. When the taps hold n ones filling bits 0..n-1 and zeros above, the quarter count is n-1, clamped to 0..3. For example, bit0=1, bit1=1, others 0 gives 1.
- R5: ctrl_word[10:2] is the coarse count, with bit 10 weighted 256 bits. ctrl_word[1] selects the half-bit stage and ctrl_word[0] the quarter-bit stage. The unsigned value of ctrl_word is the delay in quarter bits.
- R6: If the captured taps are not of the thermometer form in R4, fine_err is high together with ctrl_valid. The fine field then repeats the last legal quarter count, which is 0 after reset.
- R7: A reference marker that arrives when no cell marker is armed is ignored: ctrl_valid stays low and ctrl_word is unchanged.
- R8: While rst_n is low, ctrl_word, ctrl_valid and fine_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_mark | input | 1 | Incoming cell-start marker, one bit clock wide |
| ref_mark | input | 1 | System reference cell marker, one bit clock wide |
| fine_taps | input | 4 | Quarter-bit-spaced samples of the cell marker, bit 0 earliest |
| ctrl_word | output | 11 | Delay-stage control: coarse bits then half and quarter bits |
| ctrl_valid | output | 1 | One-cycle strobe for a new ctrl_word |
| fine_err | output | 1 | The word's fine samples were not a thermometer code |

## Verification
The fine samples take effect at the cell-marker edge. The word, valid strobe and error flag become visible one edge after the reference marker is sampled. The bench therefore drives each marker at a falling edge and counts k rising edges between the two markers. It samples the outputs at the falling edge right after the latching edge, and samples once more a cycle later to see the strobe drop. Lags from 1 to 700 bits are swept against all sixteen tap patterns. The expected word is computed as min(k,511)*4 plus a modelled quarter count that carries the last legal value across illegal patterns.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic {
        MEAS_IDLE  = 1'b0,
        MEAS_ARMED = 1'b1
    } meas_phase_e;
endpackage

// File: rtl/cps_coarse_counter.sv
module cps_coarse_counter
    import cps_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] count_o,
    output logic             capture_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        meas_phase_e      phase;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = MEAS_ARMED;
            st_d.cnt   = CNT_W'(1);
        end else if (st_q.phase == MEAS_ARMED) begin
            if (stop_i) begin
                st_d.phase = MEAS_IDLE;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: MEAS_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.cnt;
    assign capture_o = stop_i && (st_q.phase == MEAS_ARMED);

    // R1: an armed, unsaturated count advances by one per bit clock
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == MEAS_ARMED && !start_i && !stop_i && st_q.cnt != CNT_MAX)
        |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R3: a saturated count stays at its ceiling until restarted
    assert_count_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !start_i) |=> (st_q.cnt == CNT_MAX));
endmodule

// File: rtl/cps_fine_decoder.sv
module cps_fine_decoder #(
    parameter int TAPS  = 4,
    parameter int QTR_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [TAPS-1:0]  taps_i,
    output logic [QTR_W-1:0] qtr_o,
    output logic             err_o
);
    typedef struct packed {
        logic [QTR_W-1:0] qtr;
        logic             err;
    } fine_st_t;

    fine_st_t st_d, st_q;
    int       run_len;
    logic     run_open;
    logic     is_thermo;
    logic [QTR_W-1:0] decoded;

    always_comb begin
        run_len  = 0;
        run_open = 1'b1;
        for (int i = 0; i < TAPS; i++) begin
            if (run_open && taps_i[i]) begin
                run_len = run_len + 1;
            end else begin
                run_open = 1'b0;
            end
        end
        is_thermo = (taps_i == TAPS'((1 << run_len) - 1));
        decoded   = (run_len == 0) ? '0 : QTR_W'(run_len - 1);
    end

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            st_d.err = !is_thermo;
            if (is_thermo) begin
                st_d.qtr = decoded;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qtr_o = st_q.qtr;
    assign err_o = st_q.err;

    // R6: an illegal tap pattern leaves the last legal quarter count in place
    assert_fine_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !is_thermo) |=> (st_q.qtr == $past(st_q.qtr) && st_q.err));
endmodule

// File: rtl/cell_skew_gauge.sv
module cell_skew_gauge #(
    parameter int CNT_W = 9,
    parameter int TAPS  = 4,
    localparam int QTR_W = $clog2(TAPS),
    localparam int OUT_W = CNT_W + QTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_mark,
    input  logic             ref_mark,
    input  logic [TAPS-1:0]  fine_taps,
    output logic [OUT_W-1:0] ctrl_word,
    output logic             ctrl_valid,
    output logic             fine_err
);
    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             valid;
        logic             err;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic [CNT_W-1:0] coarse;
    logic             capture;
    logic [QTR_W-1:0] qtr;
    logic             qtr_err;

    cps_coarse_counter #(.CNT_W(CNT_W)) coarse_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cell_mark),
        .stop_i    (ref_mark),
        .count_o   (coarse),
        .capture_o (capture)
    );

    cps_fine_decoder #(.TAPS(TAPS), .QTR_W(QTR_W)) fine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cell_mark),
        .taps_i   (fine_taps),
        .qtr_o    (qtr),
        .err_o    (qtr_err)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        if (capture) begin
            st_d.word  = {coarse, qtr};
            st_d.valid = 1'b1;
            st_d.err   = qtr_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word  = st_q.word;
    assign ctrl_valid = st_q.valid;
    assign fine_err   = st_q.err;

    // R2, R7: the word only moves together with the valid strobe
    assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid |-> $stable(ctrl_word));

    // R1, R5: a latched coarse field is never zero
    assert_coarse_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> (ctrl_word[OUT_W-1:QTR_W] != '0));

    // R6: the error flag is only reported with a new word
    assert_err_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fine_err |-> ctrl_valid);

    // R8: reset clears the outputs
    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R8: assert (st_q == '0);
        end
    end
endmodule

// File: tb/cell_skew_gauge_tb.sv
`timescale 1ns/1ps
module cell_skew_gauge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_mark = 1'b0;
    logic        ref_mark = 1'b0;
    logic [3:0]  fine_taps = 4'd0;
    logic [10:0] ctrl_word;
    logic        ctrl_valid;
    logic        fine_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int prev_qtr = 0;

    always #2.5 clk = ~clk;

    cell_skew_gauge dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_mark  (cell_mark),
        .ref_mark   (ref_mark),
        .fine_taps  (fine_taps),
        .ctrl_word  (ctrl_word),
        .ctrl_valid (ctrl_valid),
        .fine_err   (fine_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tlen(input logic [3:0] c);
        int n = 0;
        while (n < 4 && c[n]) n++;
        return n;
    endfunction

    // one measurement: cell marker, k bit lag, reference marker
    task automatic measure(input int k, input logic [3:0] code);
        int  n;
        bit  legal;
        int  q;
        int  exp_word;
        n     = tlen(code);
        legal = (int'(code) == ((1 << n) - 1));
        q     = legal ? ((n == 0) ? 0 : n - 1) : prev_qtr;
        if (legal) prev_qtr = q;
        exp_word = ((k > 511) ? 511 : k) * 4 + q;

        @(negedge clk);
        cell_mark = 1'b1;
        fine_taps = code;
        @(posedge clk);
        @(negedge clk);
        cell_mark = 1'b0;
        fine_taps = 4'd0;
        repeat (k - 1) @(posedge clk);
        if (k > 1) @(negedge clk);
        ref_mark = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_mark = 1'b0;
        chk("R1/R3/R4/R5 word", int'(ctrl_word), exp_word);
        chk("R2 valid high", int'(ctrl_valid), 1);
        chk("R6 fine_err", int'(fine_err), legal ? 0 : 1);
        @(negedge clk);
        chk("R2 valid one cycle", int'(ctrl_valid), 0);
        chk("R2 word held", int'(ctrl_word), exp_word);
    endtask

    initial begin
        int held;
        int ks[19] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12,
                       64, 255, 256, 510, 511, 512, 700};
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 word", int'(ctrl_word), 0);
        chk("R8 valid", int'(ctrl_valid), 0);
        chk("R8 err", int'(fine_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: illegal pattern straight after reset falls back to 0
        measure(3, 4'b0101);

        foreach (ks[i]) begin
            for (int c = 0; c < 16; c++) begin
                measure(ks[i], 4'(c));
            end
        end

        // R7: reference markers with nothing armed
        held = int'(ctrl_word);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            ref_mark = 1'b1;
            @(negedge clk);
            ref_mark = 1'b0;
            chk("R7 no valid", int'(ctrl_valid), 0);
            chk("R7 word unchanged", int'(ctrl_word), held);
            @(negedge clk);
            chk("R7 no valid later", int'(ctrl_valid), 0);
        end

        // R4: the canonical single-quarter pattern after an illegal one
        measure(5, 4'b1010);
        measure(5, 4'b0011);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule